// File: doc/BRIEF.md
# Hypervisor-Aware Trap Routing Unit

This unit sits beside the privilege state of a processor core that supports a hypervisor. Each time the core raises a trap, the unit receives one event: a cause number, a flag that separates interrupts from exceptions, and a faulting address. From the current privilege level, the virtualization bit and four delegation masks, it picks one of three handlers: machine mode (M), hypervisor-supervisor mode (HS) or virtual-supervisor mode (VS). In the same clock edge it updates its own copy of the trap-related status bits, the nested hypervisor save chain, the privilege level and the virtualization state.

A generic environment-call cause is rewritten according to the mode that issued it. Guest faults always bypass the VS handler. Whenever a trap leaves a virtualized context for HS or M, the unit issues a one-cycle request to swap the hypervisor register bank. A separate context-load port lets the surrounding core set the privilege, virtualization, force flag and interrupt-enable bits, for example after a trap return. A parameter removes the hypervisor features entirely; the unit then performs plain two-way machine/supervisor delegation.

Top module: `trap_router`

## Requirements
- R1: After reset the privilege is M (code 3). The virtualization bit, the force flag, every status bit, `res_valid` and `swap_req` are all 0.
- R2: An exception with cause 8 is rewritten before delegation: to 11 from M, to 10 from S with virtualization on, to 9 from S with virtualization off, and kept at 8 from U. Interrupts are never rewritten.
- R3: A trap goes to M (target code 0) when the privilege is M, when the cause is 64 or above, or when its first-level delegation bit is clear. On such a trap MPIE takes MIE, MIE clears, MPP takes the prior privilege and the privilege becomes M.
- R4: The first-level mask is `mideleg` for interrupts and `medeleg` for exceptions. The second-level mask is `hideleg` or `hedeleg`, chosen the same way.
- R5: A delegated trap goes to VS (target code 2) only when virtualization is on, the second-level bit is set and the effective force flag is clear. The virtualization bit stays set and SPV, SP2V and SP2P keep their values.
- R6: A delegated trap that goes to HS (target code 1) shifts the save chain: SP2V takes the old SPV, SP2P takes the old SPP, and SPV takes the virtualization bit held before the trap.
- R7: An HS trap taken with virtualization on pulses `swap_req` and clears both the virtualization bit and the force flag. An HS trap taken with virtualization off leaves the force flag unchanged.
- R8: Every HS or VS trap sets SPIE to SIE, clears SIE, sets SPP to 1 exactly when the prior privilege was S, and sets the privilege to S (code 1).
- R9: Exceptions 20, 21 and 23 are guest faults. For that trap only, they raise the effective force flag (the stored flag OR the guest fault). `res_tval` is the fault address for exceptions 0, 1, 4, 5, 6, 7, 20, 21 and 23, and 0 for every other trap.
- R10: An M trap writes MPV with the prior virtualization bit and MTL with the effective force flag. It clears virtualization and the force flag, and pulses `swap_req` when virtualization was on.
- R11: `ctx_load` loads the privilege, virtualization bit, force flag, MIE and SIE. If `trap_valid` is high in the same cycle, the load is ignored.
- R12: `res_valid`, `res_target`, `res_cause` and `res_tval` are registered and appear on the cycle after `trap_valid`. `res_valid` and `swap_req` are single-cycle pulses, and `swap_req` is never high without `res_valid`.
- R13: With `HAS_HYP` = 0 the virtualization bit, SPV, SP2V, SP2P, MPV, MTL and `swap_req` stay 0, no trap reaches VS, and cause 8 from S becomes 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | One trap event this cycle |
| trap_async | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Raw cause number |
| trap_addr | input | XLEN | Faulting address |
| medeleg | input | XLEN | First-level exception delegation mask |
| mideleg | input | XLEN | First-level interrupt delegation mask |
| hedeleg | input | XLEN | Second-level exception delegation mask |
| hideleg | input | XLEN | Second-level interrupt delegation mask |
| ctx_load | input | 1 | Load the context fields below |
| ctx_priv | input | 2 | Privilege to load (0 U, 1 S, 3 M) |
| ctx_virt | input | 1 | Virtualization bit to load |
| ctx_force | input | 1 | Force flag to load |
| ctx_mie | input | 1 | MIE to load |
| ctx_sie | input | 1 | SIE to load |
| res_valid | output | 1 | Result pulse for the previous cycle's trap |
| res_target | output | 2 | 0 M, 1 HS, 2 VS |
| res_cause | output | CAUSE_W | Cause after rewriting |
| res_tval | output | XLEN | Trap value |
| swap_req | output | 1 | Hypervisor register-bank swap request |
| priv_o | output | 2 | Current privilege |
| virt_o | output | 1 | Virtualization bit |
| force_hs_o | output | 1 | Stored force flag |
| mie_o | output | 1 | MIE |
| mpie_o | output | 1 | MPIE |
| mpp_o | output | 2 | MPP |
| mpv_o | output | 1 | MPV |
| mtl_o | output | 1 | MTL |
| sie_o | output | 1 | SIE |
| spie_o | output | 1 | SPIE |
| spp_o | output | 1 | SPP |
| spv_o | output | 1 | SPV |
| sp2v_o | output | 1 | SP2V |
| sp2p_o | output | 1 | SP2P |

## Verification
A trap event and a context load can arrive in the same cycle. Both write the privilege, virtualization, force and enable bits, so the trap must win and the load must leave no trace. The bench raises `trap_valid` and `ctx_load` on the same edge, with load values chosen to differ from every field the trap computes. The scoreboard then expects exactly the trap-only state. A second overlap lies inside the HS path from a virtualized context: the save-chain shift and the clearing of the virtualization bit happen on the same edge, so SPV must capture the pre-trap value. The expected items for those traps check this.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;
   typedef enum logic [1:0] {
      PRIV_U = 2'd0,
      PRIV_S = 2'd1,
      PRIV_M = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      TGT_M  = 2'd0,
      TGT_HS = 2'd1,
      TGT_VS = 2'd2
   } tgt_e;

   localparam int unsigned EC_CALL_U   = 8;
   localparam int unsigned EC_CALL_S   = 9;
   localparam int unsigned EC_CALL_VS  = 10;
   localparam int unsigned EC_CALL_M   = 11;
   localparam int unsigned EC_GF_INST  = 20;
   localparam int unsigned EC_GF_LOAD  = 21;
   localparam int unsigned EC_GF_STORE = 23;
endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
   import trap_route_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int CAUSE_W = 7,
   parameter bit HAS_HYP = 1'b1
) (
   input  logic               is_async,
   input  logic [CAUSE_W-1:0] raw_cause,
   input  logic [XLEN-1:0]    fault_addr,
   input  logic [1:0]         cur_priv,
   input  logic               cur_virt,
   output logic [CAUSE_W-1:0] fixed_cause,
   output logic               guest_flt,
   output logic [XLEN-1:0]    tval
);
   logic is_call;
   logic base_addr_cls;

   assign is_call = !is_async && (raw_cause == CAUSE_W'(EC_CALL_U));

   // environment call: rewrite by the issuing mode
   always_comb begin
      fixed_cause = raw_cause;
      if (is_call) begin
         if (cur_priv == PRIV_M)
            fixed_cause = CAUSE_W'(EC_CALL_M);
         else if (cur_priv == PRIV_S && cur_virt)
            fixed_cause = CAUSE_W'(EC_CALL_VS);
         else if (cur_priv == PRIV_S)
            fixed_cause = CAUSE_W'(EC_CALL_S);
         else
            fixed_cause = CAUSE_W'(EC_CALL_U);
      end
   end

   // exceptions that carry an address
   always_comb begin
      case (raw_cause)
         CAUSE_W'(0), CAUSE_W'(1), CAUSE_W'(4),
         CAUSE_W'(5), CAUSE_W'(6), CAUSE_W'(7): base_addr_cls = 1'b1;
         default:                               base_addr_cls = 1'b0;
      endcase
   end

   generate
      if (HAS_HYP) begin : g_guest
         assign guest_flt = !is_async &&
                            (raw_cause == CAUSE_W'(EC_GF_INST) ||
                             raw_cause == CAUSE_W'(EC_GF_LOAD) ||
                             raw_cause == CAUSE_W'(EC_GF_STORE));
      end else begin : g_no_guest
         assign guest_flt = 1'b0;
      end
   endgenerate

   assign tval = (!is_async && (base_addr_cls || guest_flt)) ? fault_addr : '0;
endmodule

// File: rtl/trap_route_decide.sv
module trap_route_decide
   import trap_route_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int CAUSE_W = 7,
   parameter bit HAS_HYP = 1'b1
) (
   input  logic               is_async,
   input  logic [CAUSE_W-1:0] cause,
   input  logic [1:0]         cur_priv,
   input  logic               cur_virt,
   input  logic               force_eff,
   input  logic [XLEN-1:0]    medeleg,
   input  logic [XLEN-1:0]    mideleg,
   input  logic [XLEN-1:0]    hedeleg,
   input  logic [XLEN-1:0]    hideleg,
   output logic [1:0]         target
);
   localparam int IDX_W = $clog2(XLEN);

   logic             in_range;
   logic [IDX_W-1:0] idx;
   logic             lvl1;
   logic             lvl2;
   logic             sup_path;

   assign in_range = cause < CAUSE_W'(XLEN);
   assign idx      = cause[IDX_W-1:0];
   assign lvl1     = is_async ? mideleg[idx] : medeleg[idx];
   assign lvl2     = is_async ? hideleg[idx] : hedeleg[idx];
   assign sup_path = (cur_priv != PRIV_M) && in_range && lvl1;

   generate
      if (HAS_HYP) begin : g_three_way
         always_comb begin
            if (!sup_path)
               target = TGT_M;
            else if (cur_virt && lvl2 && !force_eff)
               target = TGT_VS;
            else
               target = TGT_HS;
         end
      end else begin : g_two_way
         assign target = sup_path ? TGT_HS : TGT_M;
      end
   endgenerate
endmodule

// File: rtl/trap_router.sv
module trap_router
   import trap_route_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int CAUSE_W = 7,
   parameter bit HAS_HYP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_valid,
   input  logic               trap_async,
   input  logic [CAUSE_W-1:0] trap_cause,
   input  logic [XLEN-1:0]    trap_addr,
   input  logic [XLEN-1:0]    medeleg,
   input  logic [XLEN-1:0]    mideleg,
   input  logic [XLEN-1:0]    hedeleg,
   input  logic [XLEN-1:0]    hideleg,
   input  logic               ctx_load,
   input  logic [1:0]         ctx_priv,
   input  logic               ctx_virt,
   input  logic               ctx_force,
   input  logic               ctx_mie,
   input  logic               ctx_sie,
   output logic               res_valid,
   output logic [1:0]         res_target,
   output logic [CAUSE_W-1:0] res_cause,
   output logic [XLEN-1:0]    res_tval,
   output logic               swap_req,
   output logic [1:0]         priv_o,
   output logic               virt_o,
   output logic               force_hs_o,
   output logic               mie_o,
   output logic               mpie_o,
   output logic [1:0]         mpp_o,
   output logic               mpv_o,
   output logic               mtl_o,
   output logic               sie_o,
   output logic               spie_o,
   output logic               spp_o,
   output logic               spv_o,
   output logic               sp2v_o,
   output logic               sp2p_o
);
   localparam int IDX_W = $clog2(XLEN);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("trap_router: XLEN must be 32 or 64");
      end
      if (CAUSE_W <= IDX_W || CAUSE_W < 5 || CAUSE_W > 16) begin : g_bad_cause_w
         $error("trap_router: CAUSE_W must exceed log2(XLEN), be at least 5 and at most 16");
      end
   endgenerate

   logic [CAUSE_W-1:0] fixed_w;
   logic               guest_w;
   logic [XLEN-1:0]    tval_w;
   logic [1:0]         tgt_w;
   logic               force_eff;
   logic               swap_w;

   trap_cause_fix #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_HYP(HAS_HYP)) u_fix (
      .is_async   (trap_async),
      .raw_cause  (trap_cause),
      .fault_addr (trap_addr),
      .cur_priv   (priv_o),
      .cur_virt   (virt_o),
      .fixed_cause(fixed_w),
      .guest_flt  (guest_w),
      .tval       (tval_w)
   );

   assign force_eff = force_hs_o | guest_w;

   trap_route_decide #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_HYP(HAS_HYP)) u_route (
      .is_async (trap_async),
      .cause    (fixed_w),
      .cur_priv (priv_o),
      .cur_virt (virt_o),
      .force_eff(force_eff),
      .medeleg  (medeleg),
      .mideleg  (mideleg),
      .hedeleg  (hedeleg),
      .hideleg  (hideleg),
      .target   (tgt_w)
   );

   // base privilege and interrupt-enable stack
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_target <= TGT_M;
         res_cause  <= '0;
         res_tval   <= '0;
         swap_req   <= 1'b0;
         priv_o     <= PRIV_M;
         mie_o      <= 1'b0;
         mpie_o     <= 1'b0;
         mpp_o      <= PRIV_U;
         sie_o      <= 1'b0;
         spie_o     <= 1'b0;
         spp_o      <= 1'b0;
      end else begin
         res_valid <= trap_valid;
         swap_req  <= trap_valid && swap_w;
         if (trap_valid) begin
            res_target <= tgt_w;
            res_cause  <= fixed_w;
            res_tval   <= tval_w;
            if (tgt_w == TGT_M) begin
               mpie_o <= mie_o;
               mie_o  <= 1'b0;
               mpp_o  <= priv_o;
               priv_o <= PRIV_M;
            end else begin
               spie_o <= sie_o;
               sie_o  <= 1'b0;
               spp_o  <= (priv_o == PRIV_S);
               priv_o <= PRIV_S;
            end
         end else if (ctx_load) begin
            priv_o <= ctx_priv;
            mie_o  <= ctx_mie;
            sie_o  <= ctx_sie;
         end
      end
   end

   // hypervisor state: present or tied off
   generate
      if (HAS_HYP) begin : g_hyp
         assign swap_w = virt_o && (tgt_w != TGT_VS);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               virt_o     <= 1'b0;
               force_hs_o <= 1'b0;
               mpv_o      <= 1'b0;
               mtl_o      <= 1'b0;
               spv_o      <= 1'b0;
               sp2v_o     <= 1'b0;
               sp2p_o     <= 1'b0;
            end else if (trap_valid) begin
               if (tgt_w == TGT_M) begin
                  mpv_o      <= virt_o;
                  mtl_o      <= force_eff;
                  virt_o     <= 1'b0;
                  force_hs_o <= 1'b0;
               end else if (tgt_w == TGT_HS) begin
                  sp2v_o <= spv_o;
                  sp2p_o <= spp_o;
                  spv_o  <= virt_o;
                  if (virt_o) begin
                     virt_o     <= 1'b0;
                     force_hs_o <= 1'b0;
                  end
               end
            end else if (ctx_load) begin
               virt_o     <= ctx_virt;
               force_hs_o <= ctx_force;
            end
         end

         assert_vs_keeps_virt_R5: assert property (@(posedge clk) disable iff (!rst_n)
            trap_valid && tgt_w == TGT_VS |=> virt_o && $stable(spv_o) && $stable(sp2v_o));
         assert_chain_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
            trap_valid |=> res_target != TGT_HS ||
                           (sp2v_o == $past(spv_o) && sp2p_o == $past(spp_o) && spv_o == $past(virt_o)));
         assert_leave_guest_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            trap_valid && virt_o |=> res_target == TGT_VS || (swap_req && !virt_o && !force_hs_o));
         assert_guest_not_vs_R9: assert property (@(posedge clk) disable iff (!rst_n)
            trap_valid && guest_w |-> tgt_w != TGT_VS);
         assert_mtrap_save_R10: assert property (@(posedge clk) disable iff (!rst_n)
            trap_valid |=> res_target != TGT_M || (mpv_o == $past(virt_o) && !virt_o && !force_hs_o));
      end else begin : g_no_hyp
         assign swap_w     = 1'b0;
         assign virt_o     = 1'b0;
         assign force_hs_o = 1'b0;
         assign mpv_o      = 1'b0;
         assign mtl_o      = 1'b0;
         assign spv_o      = 1'b0;
         assign sp2v_o     = 1'b0;
         assign sp2p_o     = 1'b0;

         assert_never_vs_R13: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid |-> res_target != TGT_VS && !swap_req);
      end
   endgenerate

   assert_mcall_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid && !trap_async && trap_cause == CAUSE_W'(EC_CALL_U) && priv_o == PRIV_M
      |=> res_cause == CAUSE_W'(EC_CALL_M));
   assert_mtarget_priv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> (res_target == TGT_M) == (priv_o == PRIV_M));
   assert_mtrap_stack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> res_target != TGT_M || (mpie_o == $past(mie_o) && mpp_o == $past(priv_o) && !mie_o));
   assert_strap_stack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> res_target == TGT_M || (spie_o == $past(sie_o) && !sie_o));
   assert_load_applies_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_load && !trap_valid |=> priv_o == $past(ctx_priv));
   assert_result_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> res_valid);
   assert_no_stray_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid |=> !res_valid && !swap_req);
endmodule

// File: tb/trap_router_tb.sv
module trap_router_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_valid = 1'b0, trap_async = 1'b0;
   logic [6:0]  trap_cause = '0;
   logic [63:0] trap_addr = '0;
   logic [63:0] med = '0, mid = '0, hed = '0, hid = '0;
   logic        ctx_load = 1'b0, ctx_virt = 1'b0, ctx_force = 1'b0, ctx_mie = 1'b0, ctx_sie = 1'b0;
   logic [1:0]  ctx_priv = '0;

   logic        res_valid, swap_req, virt_o, force_hs_o, mie_o, mpie_o, mpv_o, mtl_o;
   logic        sie_o, spie_o, spp_o, spv_o, sp2v_o, sp2p_o;
   logic [1:0]  res_target, priv_o, mpp_o;
   logic [6:0]  res_cause;
   logic [63:0] res_tval;

   logic        n_valid, n_swap, n_virt, n_force, n_mie, n_mpie, n_mpv, n_mtl;
   logic        n_sie, n_spie, n_spp, n_spv, n_sp2v, n_sp2p;
   logic [1:0]  n_target, n_priv, n_mpp;
   logic [6:0]  n_cause;
   logic [63:0] n_tval;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   trap_router u_dut (
      .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_async(trap_async),
      .trap_cause(trap_cause), .trap_addr(trap_addr), .medeleg(med), .mideleg(mid),
      .hedeleg(hed), .hideleg(hid), .ctx_load(ctx_load), .ctx_priv(ctx_priv),
      .ctx_virt(ctx_virt), .ctx_force(ctx_force), .ctx_mie(ctx_mie), .ctx_sie(ctx_sie),
      .res_valid(res_valid), .res_target(res_target), .res_cause(res_cause),
      .res_tval(res_tval), .swap_req(swap_req), .priv_o(priv_o), .virt_o(virt_o),
      .force_hs_o(force_hs_o), .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o),
      .mpv_o(mpv_o), .mtl_o(mtl_o), .sie_o(sie_o), .spie_o(spie_o), .spp_o(spp_o),
      .spv_o(spv_o), .sp2v_o(sp2v_o), .sp2p_o(sp2p_o)
   );

   trap_router #(.HAS_HYP(1'b0)) u_nohyp (
      .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_async(trap_async),
      .trap_cause(trap_cause), .trap_addr(trap_addr), .medeleg(med), .mideleg(mid),
      .hedeleg(hed), .hideleg(hid), .ctx_load(ctx_load), .ctx_priv(ctx_priv),
      .ctx_virt(ctx_virt), .ctx_force(ctx_force), .ctx_mie(ctx_mie), .ctx_sie(ctx_sie),
      .res_valid(n_valid), .res_target(n_target), .res_cause(n_cause),
      .res_tval(n_tval), .swap_req(n_swap), .priv_o(n_priv), .virt_o(n_virt),
      .force_hs_o(n_force), .mie_o(n_mie), .mpie_o(n_mpie), .mpp_o(n_mpp),
      .mpv_o(n_mpv), .mtl_o(n_mtl), .sie_o(n_sie), .spie_o(n_spie), .spp_o(n_spp),
      .spv_o(n_spv), .sp2v_o(n_sp2v), .sp2p_o(n_sp2p)
   );

   // reference state, built from the requirements
   logic [1:0] m_priv = 2'd3, m_mpp = 2'd0;
   logic m_virt = 0, m_force = 0, m_mie = 0, m_mpie = 0, m_mpv = 0, m_mtl = 0;
   logic m_sie = 0, m_spie = 0, m_spp = 0, m_spv = 0, m_sp2v = 0, m_sp2p = 0;

   typedef struct {
      logic [1:0]  tgt;
      logic [6:0]  cause;
      logic [63:0] tval;
      logic        swap;
      logic [15:0] st;
      string       tag;
   } exp_t;
   exp_t q[$];

   logic [15:0] dut_st;
   assign dut_st = {priv_o, virt_o, force_hs_o, mie_o, mpie_o, mpp_o, mpv_o, mtl_o,
                    sie_o, spie_o, spp_o, spv_o, sp2v_o, sp2p_o};

   function automatic logic [15:0] model_st();
      return {m_priv, m_virt, m_force, m_mie, m_mpie, m_mpp, m_mpv, m_mtl,
              m_sie, m_spie, m_spp, m_spv, m_sp2v, m_sp2p};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("[TB] FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // monitor: pop expected items as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (res_valid) begin
            if (q.size() == 0) begin
               chk(1'b0, "R12 unexpected result", 64'(res_cause), 64'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk({res_target, res_cause, swap_req, dut_st} == {e.tgt, e.cause, e.swap, e.st},
                   e.tag, 64'({res_target, res_cause, swap_req, dut_st}),
                   64'({e.tgt, e.cause, e.swap, e.st}));
               chk(res_tval == e.tval, {e.tag, " tval R9"}, res_tval, e.tval);
            end
         end else if (swap_req) begin
            chk(1'b0, "R12 swap without result", 64'(swap_req), 64'd0);
         end
      end
   end

   // driver: predict, queue, then drive one trap
   task automatic do_trap(input bit a, input int cause, input logic [63:0] addr,
                          input bit collide, input string tag);
      exp_t e;
      int c;
      bit guest, sup, d1, d2, fe;
      c = cause;
      if (!a && c == 8)
         c = (m_priv == 2'd3) ? 11 : (m_priv == 2'd1 && m_virt) ? 10 : (m_priv == 2'd1) ? 9 : 8;
      guest = !a && (c == 20 || c == 21 || c == 23);
      e.tval = (!a && (c <= 1 || (c >= 4 && c <= 7) || guest)) ? addr : 64'd0;
      fe  = m_force | guest;
      d1  = (c < 64) ? (a ? mid[c] : med[c]) : 1'b0;
      d2  = (c < 64) ? (a ? hid[c] : hed[c]) : 1'b0;
      sup = (m_priv != 2'd3) && (c < 64) && d1;
      e.cause = 7'(c);
      e.swap  = 1'b0;
      if (sup) begin
         if (m_virt && d2 && !fe) begin
            e.tgt = 2'd2;
         end else begin
            e.tgt  = 2'd1;
            m_sp2v = m_spv;
            m_sp2p = m_spp;
            m_spv  = m_virt;
            if (m_virt) begin
               e.swap  = 1'b1;
               m_virt  = 1'b0;
               m_force = 1'b0;
            end
         end
         m_spie = m_sie;
         m_sie  = 1'b0;
         m_spp  = (m_priv == 2'd1);
         m_priv = 2'd1;
      end else begin
         e.tgt   = 2'd0;
         e.swap  = m_virt;
         m_mpv   = m_virt;
         m_mtl   = fe;
         m_virt  = 1'b0;
         m_force = 1'b0;
         m_mpie  = m_mie;
         m_mie   = 1'b0;
         m_mpp   = m_priv;
         m_priv  = 2'd3;
      end
      e.st  = model_st();
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      trap_valid = 1'b1;
      trap_async = a;
      trap_cause = 7'(cause);
      trap_addr  = addr;
      if (collide) begin
         ctx_load = 1'b1; ctx_priv = 2'd0; ctx_virt = 1'b1;
         ctx_force = 1'b1; ctx_mie = 1'b1; ctx_sie = 1'b1;
      end
      @(negedge clk);
      trap_valid = 1'b0;
      ctx_load   = 1'b0;
   endtask

   task automatic do_load(input logic [1:0] p, input bit v, input bit f, input bit me, input bit se);
      @(negedge clk);
      ctx_load = 1'b1; ctx_priv = p; ctx_virt = v; ctx_force = f; ctx_mie = me; ctx_sie = se;
      @(negedge clk);
      ctx_load = 1'b0;
      m_priv = p; m_virt = v; m_force = f; m_mie = me; m_sie = se;
      chk(dut_st == model_st(), "R11 context load", 64'(dut_st), 64'(model_st()));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      med = 64'(1) << 2 | 64'(1) << 5 | 64'(1) << 8 | 64'(1) << 9 | 64'(1) << 10 |
            64'(1) << 13 | 64'(1) << 20 | 64'(1) << 21;
      mid = 64'(1) << 1 | 64'(1) << 5 | 64'(1) << 9;
      hed = 64'(1) << 2 | 64'(1) << 8 | 64'(1) << 10 | 64'(1) << 13 | 64'(1) << 20 | 64'(1) << 21;
      hid = 64'(1) << 1 | 64'(1) << 5;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      chk(dut_st == 16'hC000, "R1 reset state", 64'(dut_st), 64'hC000);
      chk(!res_valid && !swap_req, "R1 reset pulses", 64'({res_valid, swap_req}), 64'd0);

      do_trap(1'b0, 8, 64'h10, 1'b0, "R2 R3 call from M");
      do_load(2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      do_trap(1'b0, 8, 64'h20, 1'b0, "R2 R6 R8 call from U to HS");
      do_trap(1'b0, 8, 64'h30, 1'b0, "R2 R6 R8 call from S to HS");
      do_load(2'd1, 1'b1, 1'b0, 1'b1, 1'b1);
      do_trap(1'b0, 8, 64'h40, 1'b0, "R2 R5 call from VS to VS");
      do_trap(1'b0, 5, 64'hDEAD_BEEF, 1'b0, "R7 R6 R9 fault leaves guest");
      do_load(2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
      do_trap(1'b0, 21, 64'h1234_5678, 1'b0, "R9 R7 guest fault forced to HS");
      do_load(2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
      do_trap(1'b1, 5, 64'h55, 1'b0, "R4 R7 stored force blocks VS");
      do_load(2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
      do_trap(1'b0, 2, 64'h60, 1'b0, "R5 R9 VS trap without address");
      do_trap(1'b0, 3, 64'h70, 1'b0, "R10 R3 guest to M");
      do_load(2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
      do_trap(1'b0, 23, 64'hABCD, 1'b0, "R10 R9 guest fault to M");
      do_load(2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      do_trap(1'b1, 1, 64'h80, 1'b0, "R4 interrupt 1 delegated");
      do_load(2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      do_trap(1'b0, 1, 64'h90, 1'b0, "R4 R9 exception 1 to M");
      do_load(2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
      do_trap(1'b1, 8, 64'hA0, 1'b0, "R2 R4 interrupt 8 not rewritten");
      do_load(2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      do_trap(1'b0, 70, 64'hB0, 1'b0, "R3 cause above range");
      do_load(2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
      do_trap(1'b0, 9, 64'hC0, 1'b1, "R11 load ignored under trap");

      // R13: two-way unit after a load that asks for virtualization
      do_load(2'd1, 1'b1, 1'b0, 1'b1, 1'b1);
      chk(n_virt == 1'b0 && n_priv == 2'd1, "R13 no virtualization", 64'({n_priv, n_virt}), 64'h2);
      do_trap(1'b0, 8, 64'hD0, 1'b0, "R5 VS call alongside R13");
      chk(n_target == 2'd1 && n_cause == 7'd9, "R13 call from S",
          64'({n_target, n_cause}), 64'({2'd1, 7'd9}));
      chk({n_spv, n_sp2v, n_sp2p, n_swap} == 4'd0, "R13 chain stays clear",
          64'({n_spv, n_sp2v, n_sp2p, n_swap}), 64'd0);
      do_trap(1'b0, 3, 64'hE0, 1'b0, "R10 VS to M alongside R13");
      chk(n_target == 2'd0 && n_mpv == 1'b0 && n_mtl == 1'b0 && n_swap == 1'b0,
          "R13 M trap", 64'({n_target, n_mpv, n_mtl, n_swap}), 64'd0);

      repeat (3) @(negedge clk);
      chk(q.size() == 0, "R12 all results seen", 64'(q.size()), 64'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule